// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one word-sized atomic memory operation for a pipeline. The pipeline pulses `start_i` with the instruction word and both source register values. The unit decodes the operation and reads the 32-bit word at the address given by the first source value. It then combines that word with the second source value, writes the result back to the same address, and returns the value it read so that it can be written to the destination register.

Toward memory it has a request port with a valid/ready handshake and a one-cycle response strobe. The response strobe returns read data and also acknowledges writes. A lock output stays high from the read request through the write acknowledge, so that no other requester can get in between the two accesses. The pipeline sees `busy_o` for the whole operation and a one-cycle `done_o` at the end. An instruction the unit does not recognise produces a one-cycle `illegal_o` and no memory traffic.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is accepted only when bits 6:0 equal 0101111 and bits 14:12 equal 010. Any other word produces `illegal_o` high for exactly the cycle after `start_i`, together with `busy_o`, and causes no memory request and no `done_o`.
- R2: Bits 31:27 select the operation: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. Any other code is treated as illegal, as in R1.
- R3: The read request and the write request both carry the full first source value as the address. The read is issued before the write.
- R4: Swap writes the second source value to memory unchanged.
- R5: Add, xor, and, and or write the old memory word combined with the second source value (add wraps modulo 2^32).
- R6: Signed min and signed max compare the two operands as two's-complement numbers and write the selected one.
- R7: Unsigned min and unsigned max compare the two operands as unsigned numbers and write the selected one.
- R8: `rd_data_o` is the old memory word, sign-extended to XLEN. `rd_we_o` is high only in the `done_o` cycle and only when the destination index (bits 11:7) is non-zero. The memory write takes place in either case.
- R9: After reset, busy, done, illegal, request and lock outputs are all low. `busy_o` is high from the cycle after an accepted start up to and including the single `done_o` cycle.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The operation in progress keeps its address and operands, and no second operation follows.
- R11: `mem_lock_o` is high from the read request until the write response, and low otherwise, including during the `done_o` cycle.
- R12: Bits 26 and 25 of an accepted instruction are presented on `aq_o` and `rl_o` for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (honoured only when idle) |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | First source value, used as the address |
| rs2_val_i | input | XLEN | Second source value, the operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | One-cycle strobe for an unrecognised instruction |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | XLEN | Old memory value, sign-extended |
| aq_o | output | 1 | Acquire flag carried through |
| rl_o | output | 1 | Release flag carried through |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | XLEN | Request address |
| mem_wdata_o | output | 32 | Write data |
| mem_lock_o | output | 1 | Exclusive-access hold |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_i | input | 1 | Read data valid or write acknowledged |
| mem_rdata_i | input | 32 | Read data |

## Verification
Assertions check the following on every clock:
- `done_o` never lasts two cycles.
- Every request is made under the lock.
- An illegal strobe never coincides with a request or a completion.
- The address stays fixed while busy.
- A register write never targets index zero.

The bench's scenarios are needed to show the rest:
- each of the nine combine rules, including the cases where signed and unsigned ordering disagree and the case where an add wraps;
- the value returned for the destination register;
- the rejection of each malformed field;
- that a start arriving mid-operation leaves no trace in memory or on the outputs.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [6:0] AMO_OPCODE = 7'b0101111;
  localparam logic [2:0] AMO_WORD_F3 = 3'b010;
  localparam int unsigned MEM_W = 32;

  typedef enum logic [3:0] {
    AMO_SWAP, AMO_ADD, AMO_XOR, AMO_AND, AMO_OR,
    AMO_MIN, AMO_MAX, AMO_MINU, AMO_MAXU
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_DONE, ST_ILL
  } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] width_i,
  input  logic [4:0] func_i,
  output logic       legal_o,
  output amo_op_e    op_o
);
  logic func_known;

  always_comb begin
    func_known = 1'b1;
    op_o       = AMO_SWAP;
    unique case (func_i)
      5'b00001: op_o = AMO_SWAP;
      5'b00000: op_o = AMO_ADD;
      5'b00100: op_o = AMO_XOR;
      5'b01100: op_o = AMO_AND;
      5'b01000: op_o = AMO_OR;
      5'b10000: op_o = AMO_MIN;
      5'b10100: op_o = AMO_MAX;
      5'b11000: op_o = AMO_MINU;
      5'b11100: op_o = AMO_MAXU;
      default:  func_known = 1'b0;
    endcase
  end

  assign legal_o = func_known && (opcode_i == AMO_OPCODE) && (width_i == AMO_WORD_F3);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  amo_op_e         op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] new_o
);
  logic lt_signed;
  logic lt_unsigned;

  assign lt_signed   = $signed(old_i) < $signed(src_i);
  assign lt_unsigned = old_i < src_i;

  always_comb begin
    unique case (op_i)
      AMO_SWAP: new_o = src_i;
      AMO_ADD:  new_o = old_i + src_i;
      AMO_XOR:  new_o = old_i ^ src_i;
      AMO_AND:  new_o = old_i & src_i;
      AMO_OR:   new_o = old_i | src_i;
      AMO_MIN:  new_o = lt_signed   ? old_i : src_i;
      AMO_MAX:  new_o = lt_signed   ? src_i : old_i;
      AMO_MINU: new_o = lt_unsigned ? old_i : src_i;
      AMO_MAXU: new_o = lt_unsigned ? src_i : old_i;
      default:  new_o = src_i;
    endcase
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       legal_i,
  input  logic       mem_ready_i,
  input  logic       mem_rsp_i,
  output amo_state_e state_o
);
  amo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = legal_i ? ST_RD_REQ : ST_ILL;
      ST_RD_REQ:  if (mem_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (mem_ready_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rsp_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      ST_ILL:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R9
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE || state_q == ST_ILL) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            rd_we_o,
  output logic [4:0]      rd_idx_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            aq_o,
  output logic            rl_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  output logic            mem_lock_o,
  input  logic            mem_ready_i,
  input  logic            mem_rsp_i,
  input  logic [31:0]     mem_rdata_i
);
  localparam int unsigned RD_W = 5;

  amo_state_e state;
  amo_op_e    op_dec, op_q;
  logic       legal;
  logic       accept;
  logic       capture;
  logic       unused_fields;

  logic [RD_W-1:0] rd_q;
  logic            aq_q, rl_q;
  logic [XLEN-1:0] addr_q, src_q, old_q, new_val, old_ext;
  logic signed [MEM_W-1:0] rdata_s;

  assign unused_fields = ^insn_i[24:15];

  amo_decode u_decode (
    .opcode_i (insn_i[6:0]),
    .width_i  (insn_i[14:12]),
    .func_i   (insn_i[31:27]),
    .legal_o  (legal),
    .op_o     (op_dec)
  );

  amo_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .legal_i     (legal),
    .mem_ready_i (mem_ready_i),
    .mem_rsp_i   (mem_rsp_i),
    .state_o     (state)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (op_q),
    .old_i (old_q),
    .src_i (src_q),
    .new_o (new_val)
  );

  assign accept  = start_i && legal && (state == ST_IDLE);
  assign capture = mem_rsp_i && (state == ST_RD_WAIT);
  assign rdata_s = $signed(mem_rdata_i);
  assign old_ext = XLEN'(rdata_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= AMO_SWAP;
      rd_q   <= '0;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      addr_q <= '0;
      src_q  <= '0;
    end else if (accept) begin
      op_q   <= op_dec;
      rd_q   <= insn_i[11:7];
      aq_q   <= insn_i[26];
      rl_q   <= insn_i[25];
      addr_q <= rs1_val_i;
      src_q  <= rs2_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       old_q <= '0;
    else if (capture) old_q <= old_ext;
  end

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign illegal_o   = (state == ST_ILL);
  assign mem_req_o   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_we_o    = (state == ST_WR_REQ);
  assign mem_lock_o  = (state == ST_RD_REQ) || (state == ST_RD_WAIT) ||
                       (state == ST_WR_REQ) || (state == ST_WR_WAIT);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_val[MEM_W-1:0];
  assign rd_we_o     = done_o && (rd_q != '0);
  assign rd_idx_o    = rd_q;
  assign rd_data_o   = old_q;
  assign aq_o        = aq_q;
  assign rl_o        = rl_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11
  lock_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_lock_o);
  // R1
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!mem_req_o && !done_o && !mem_lock_o));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mem_addr_o));
  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (done_o && rd_idx_o != '0));
endmodule

// File: tb/tb_amo_rmw_unit.sv
module tb_amo_rmw_unit;
  localparam int XLEN = 32;

  logic clk, rst_n, start_i;
  logic [31:0] insn_i;
  logic [XLEN-1:0] rs1_val_i, rs2_val_i;
  logic busy_o, done_o, illegal_o, rd_we_o, aq_o, rl_o;
  logic [4:0] rd_idx_o;
  logic [XLEN-1:0] rd_data_o, mem_addr_o;
  logic mem_req_o, mem_we_o, mem_lock_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic mem_ready_i, mem_rsp_i;

  amo_rmw_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
    .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
    .aq_o(aq_o), .rl_o(rl_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_lock_o(mem_lock_o),
    .mem_ready_i(mem_ready_i), .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model and expected image
  logic [31:0] ram [16];
  logic [31:0] exp_ram [16];
  logic [31:0] cur_rs1;
  bit inflight = 0;
  int lat_cfg = 0;
  int cyc = 0;
  bit pend = 0;
  bit pend_we;
  logic [31:0] pend_addr, pend_wdata;
  int pend_cnt;
  int rd_reqs, wr_reqs;

  function automatic logic [31:0] addr_of(input int idx);
    return 32'h8000_0000 + 32'(idx * 4);
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] f5, input logic aq, input logic rl,
                                     input logic [4:0] rd, input logic [2:0] f3, input logic [6:0] opc);
    return {f5, aq, rl, 5'd7, 5'd6, f3, rd, opc};
  endfunction

  function automatic logic [31:0] ref_new(input logic [4:0] f5, input logic [31:0] o, input logic [31:0] b);
    int signed so, sb;
    so = o; sb = b;
    case (f5)
      5'b00001: return b;
      5'b00000: return o + b;
      5'b00100: return o ^ b;
      5'b01100: return o & b;
      5'b01000: return o | b;
      5'b10000: return (so <= sb) ? o : b;
      5'b10100: return (so >= sb) ? o : b;
      5'b11000: return (o <= b) ? o : b;
      5'b11100: return (o >= b) ? o : b;
      default:  return o;
    endcase
  endfunction

  // Responder: handshake seen at the edge, reply driven at the falling edge
  always @(posedge clk) begin
    if (rst_n && mem_req_o && mem_ready_i) begin
      pend = 1; pend_we = mem_we_o; pend_addr = mem_addr_o; pend_wdata = mem_wdata_o;
      pend_cnt = lat_cfg;
      if (mem_we_o) wr_reqs++; else rd_reqs++;
      // R3: address equals the full first source value; write only after a read
      chk(mem_addr_o == cur_rs1, "R3", mem_addr_o, cur_rs1);
      if (mem_we_o) chk(rd_reqs == 1 && wr_reqs == 1, "R3", 64'(rd_reqs), 64'd1);
    end
  end

  always @(negedge clk) begin
    mem_rsp_i = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_i = 1'b1;
        if (pend_we) ram[pend_addr[5:2]] = pend_wdata;
        else mem_rdata_i = ram[pend_addr[5:2]];
        pend = 0;
      end else pend_cnt--;
    end
    cyc++;
    mem_ready_i = ((cyc % 3) != 1);
  end

  // Per-cycle comparison against the model's view of the operation
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      // R11
      chk(mem_lock_o == (inflight && !done_o), "R11", mem_lock_o, inflight && !done_o);
      if (!inflight) begin
        // R10 / R1: nothing moves without an accepted operation
        chk(!mem_req_o && !done_o, "R10", {mem_req_o, done_o}, 0);
      end
    end
  end

  task automatic run_op(input logic [4:0] f5, input logic aq, input logic rl, input logic [4:0] rd,
                        input logic [2:0] f3, input logic [6:0] opc, input int idx,
                        input logic [31:0] b, input bit inject, input string req);
    bit legal;
    logic [31:0] old, nv;
    int n;
    legal = (opc == 7'b0101111) && (f3 == 3'b010) &&
            (f5 inside {5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                        5'b10000, 5'b10100, 5'b11000, 5'b11100});
    old = exp_ram[idx];
    nv  = ref_new(f5, old, b);
    rd_reqs = 0; wr_reqs = 0;
    @(negedge clk);
    start_i = 1'b1; insn_i = mk(f5, aq, rl, rd, f3, opc);
    rs1_val_i = addr_of(idx); rs2_val_i = b; cur_rs1 = addr_of(idx);
    @(negedge clk);
    start_i = 1'b0;
    if (!legal) begin
      chk(illegal_o && busy_o, "R1", {illegal_o, busy_o}, 2'b11);
      @(negedge clk);
      chk(!illegal_o && !busy_o, "R2", {illegal_o, busy_o}, 0);
      chk(ram[idx] == exp_ram[idx], "R1", ram[idx], exp_ram[idx]);
      chk(rd_reqs == 0, "R1", 64'(rd_reqs), 0);
      return;
    end
    inflight = 1;
    chk(busy_o, "R9", busy_o, 1);
    chk(aq_o == aq && rl_o == rl, "R12", {aq_o, rl_o}, {aq, rl});
    if (inject) begin
      start_i = 1'b1; insn_i = mk(5'b00001, 1'b0, 1'b0, 5'd9, 3'b010, 7'b0101111);
      rs1_val_i = addr_of(15); rs2_val_i = 32'hDEAD_BEEF;
    end
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
      if (!done_o) chk(busy_o && aq_o == aq && rl_o == rl, "R12", {busy_o, aq_o, rl_o}, {1'b1, aq, rl});
    end
    exp_ram[idx] = nv;
    chk(done_o, "R9", done_o, 1);
    chk(rd_data_o == old, "R8", rd_data_o, old);
    chk(rd_we_o == (rd != 0), "R8", rd_we_o, rd != 0);
    chk(rd_idx_o == rd, "R8", rd_idx_o, rd);
    chk(ram[idx] == nv, req, ram[idx], nv);
    chk(rd_reqs == 1 && wr_reqs == 1, "R3", {rd_reqs[7:0], wr_reqs[7:0]}, 16'h0101);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9", {done_o, busy_o}, 0);
    inflight = 0;
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(!busy_o && ram[15] == exp_ram[15], "R10", ram[15], exp_ram[15]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = 32'h0101_0000 * i + 32'h10 * i;
      exp_ram[i] = ram[i];
    end
    ram[3] = 32'h8000_0000; exp_ram[3] = ram[3];
    ram[4] = 32'hFFFF_FFF0; exp_ram[4] = ram[4];
    ram[5] = 32'hFFFF_FFFF; exp_ram[5] = ram[5];
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; rs1_val_i = '0; rs2_val_i = '0;
    mem_ready_i = 1'b0; mem_rsp_i = 1'b0; mem_rdata_i = '0; cur_rs1 = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy_o && !done_o && !illegal_o && !mem_req_o && !mem_lock_o, "R9",
        {busy_o, done_o, illegal_o, mem_req_o, mem_lock_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    lat_cfg = 0;
    run_op(5'b00001, 0, 0, 5'd5, 3'b010, 7'b0101111, 1, 32'h1234_5678, 0, "R4");
    run_op(5'b00000, 0, 0, 5'd6, 3'b010, 7'b0101111, 2, 32'h0000_0100, 0, "R5");
    lat_cfg = 2;
    run_op(5'b00000, 1, 0, 5'd6, 3'b010, 7'b0101111, 5, 32'h0000_0001, 0, "R5");
    run_op(5'b00100, 0, 1, 5'd7, 3'b010, 7'b0101111, 6, 32'hF0F0_F0F0, 0, "R5");
    lat_cfg = 1;
    run_op(5'b01100, 1, 1, 5'd8, 3'b010, 7'b0101111, 7, 32'h0F0F_FFFF, 0, "R5");
    run_op(5'b01000, 0, 0, 5'd9, 3'b010, 7'b0101111, 8, 32'h8000_0001, 0, "R5");
    // signed vs unsigned ordering disagree for 0x8000_0000 against 1
    run_op(5'b10000, 0, 0, 5'd10, 3'b010, 7'b0101111, 3, 32'h0000_0001, 0, "R6");
    run_op(5'b10100, 0, 0, 5'd11, 3'b010, 7'b0101111, 4, 32'h0000_0002, 0, "R6");
    run_op(5'b11000, 0, 0, 5'd12, 3'b010, 7'b0101111, 4, 32'h0000_0002, 0, "R7");
    run_op(5'b11100, 0, 0, 5'd13, 3'b010, 7'b0101111, 9, 32'hFFFF_0000, 0, "R7");
    run_op(5'b10100, 0, 0, 5'd14, 3'b010, 7'b0101111, 10, 32'hFFFF_FFFF, 0, "R6");
    run_op(5'b11000, 0, 0, 5'd15, 3'b010, 7'b0101111, 11, 32'hFFFF_FFFF, 0, "R7");
    lat_cfg = 0;
    // R8: destination zero still updates memory
    run_op(5'b00000, 0, 0, 5'd0, 3'b010, 7'b0101111, 12, 32'h0000_0033, 0, "R8");
    // R10: start while busy
    run_op(5'b00100, 0, 0, 5'd3, 3'b010, 7'b0101111, 13, 32'h0000_FFFF, 1, "R10");
    // R2 unknown codes, R1 wrong opcode or width
    run_op(5'b00010, 0, 0, 5'd3, 3'b010, 7'b0101111, 14, 32'h1, 0, "R2");
    run_op(5'b11111, 0, 0, 5'd3, 3'b010, 7'b0101111, 14, 32'h1, 0, "R2");
    run_op(5'b00000, 0, 0, 5'd3, 3'b010, 7'b0110011, 14, 32'h1, 0, "R1");
    run_op(5'b00000, 0, 0, 5'd3, 3'b011, 7'b0101111, 14, 32'h1, 0, "R1");
    // legal op right after an illegal one
    run_op(5'b00001, 1, 0, 5'd4, 3'b010, 7'b0101111, 14, 32'hCAFE_0000, 0, "R4");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule